// File: doc/BRIEF.md
# Two-Wire Phase-Coded Serial Transmitter

This block turns 32-bit words into a bit stream on a pair of wires, P and N. When the line is idle, both wires are high. Each bit takes two phases of equal length. In the first phase both wires are pulled low. In the second phase exactly one wire is raised, and which one it is gives the bit value: N for a zero, P for a one. There are no start or stop bits. Idle periods alone mark where a transaction begins and ends.

Words enter through a valid/ready handshake together with a last-word flag. A word sent without the flag is followed directly by the next word, with no idle between them. A word sent with the flag ends the transaction with a guard idle, and the next transaction cannot start until that guard has passed. Phase lengths are counted in system-clock cycles, and the count is set by parameters. The same block can drive a result-reporting link or pass configuration words along to the next device in a chain.

Top module: `tw_line_tx`

## Requirements
- R1: While `rst` is high, both wires are high and `in_ready` is low. This holds from the clock edge after `rst` is first sampled high.
- R2: Every bit opens with both wires low for exactly PHASE_CYCLES cycles. From the idle level (both high), the line can only move to both low.
- R3: A 0 bit drives P=0 and N=1 in its second phase for at least PHASE_CYCLES cycles. From this pattern the line can only move to both low or both high.
- R4: A 1 bit drives P=1 and N=0 in its second phase for at least PHASE_CYCLES cycles.
- R5: An accepted word is sent as exactly WORD_W bits, bit 0 first and bit WORD_W-1 last. Words go out in the order they are accepted.
- R6: A word is accepted on a clock edge where `in_valid` and `in_ready` are both high. After that, `in_ready` stays low until the second phase of the word's last bit has completed. `in_valid` and `in_data` have no effect while `in_ready` is low.
- R7: After a word accepted with `in_last`=0, the wires hold the last bit's second-phase pattern and `in_ready` is high. The next accepted word's first low phase follows directly, with no idle in between.
- R8: After the final bit of a word accepted with `in_last`=1, and also after reset, both wires stay high for exactly GUARD_PHASES*PHASE_CYCLES cycles before `in_ready` rises.
- R9: Sending the word 0x000000CA produces 0,1,0,1,0,0,1,1 as its first eight symbols.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Word offered |
| in_ready | output | 1 | Transmitter can take a word |
| in_data | input | WORD_W | Word to serialize, bit 0 sent first |
| in_last | input | 1 | Accepted word closes the transaction |
| line_p | output | 1 | Wire P, high when idle |
| line_n | output | 1 | Wire N, high when idle |

## Verification
The assertions assume three things about the inputs. First, `rst` is held high for at least one clock edge at start-up. Second, `in_last` matters only on the accepting edge. Third, inputs change only between clock edges. The bench drives every input shortly after a rising edge, so it never changes them at an edge. It keeps `in_valid` high until the word is accepted. In one test it also raises `in_valid` with different data while a word is shifting, to show that this has no effect. A bench monitor decodes the wires on falling edges. It measures each low, data and idle run and checks every transition between line states, independently of the design's internal counters.

// File: rtl/tw_tx_pkg.sv
package tw_tx_pkg;
  typedef enum logic [2:0] {
    ST_GUARD,  // wires high, closing or post-reset idle
    ST_WAIT,   // wires high, ready for a new transaction
    ST_LOW,    // first phase of a bit: both wires low
    ST_HIGH,   // second phase of a bit: one wire raised
    ST_HOLD    // last bit of a non-final word held, ready for next word
  } tx_state_e;
endpackage

// File: rtl/tw_phase_timer.sv
module tw_phase_timer #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clr,
  input  logic [CNT_W-1:0] len,
  output logic             done
);
  logic [CNT_W-1:0] cnt_q;

  assign done = (cnt_q == len - CNT_W'(1));

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= '0;
    end else if (clr) begin
      cnt_q <= '0;
    end else if (!done) begin
      cnt_q <= cnt_q + CNT_W'(1);
    end
  end
endmodule

// File: rtl/tw_word_shifter.sv
module tw_word_shifter #(
  parameter int WORD_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              load,
  input  logic              adv,
  input  logic [WORD_W-1:0] din,
  output logic              bit_nxt,
  output logic              at_last
);
  localparam int IDX_W = (WORD_W > 1) ? $clog2(WORD_W) : 1;

  logic [WORD_W-1:0] sh_q;
  logic [IDX_W-1:0]  idx_q;

  assign at_last = (idx_q == IDX_W'(WORD_W - 1));

  always_comb begin
    if (load)     bit_nxt = din[0];
    else if (adv) bit_nxt = sh_q[1];
    else          bit_nxt = sh_q[0];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      sh_q  <= '0;
      idx_q <= '0;
    end else if (load) begin
      sh_q  <= din;
      idx_q <= '0;
    end else if (adv) begin
      sh_q  <= sh_q >> 1;
      idx_q <= idx_q + IDX_W'(1);
    end
  end

  AST_LOAD_ADV_EXCL: assert property (@(posedge clk) disable iff (rst)
    !(load && adv)); // R5
endmodule

// File: rtl/tw_line_tx.sv
module tw_line_tx
  import tw_tx_pkg::*;
#(
  parameter int WORD_W       = 32,
  parameter int PHASE_CYCLES = 13,
  parameter int GUARD_PHASES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [WORD_W-1:0] in_data,
  input  logic              in_last,
  output logic              line_p,
  output logic              line_n
);
  localparam int GUARD_LEN = PHASE_CYCLES * GUARD_PHASES;
  localparam int CNT_W     = $clog2(GUARD_LEN + 1);

  tx_state_e        state_q, state_d;
  logic             last_q;
  logic             accept, adv, t_done, t_clr;
  logic             bit_d, at_last;
  logic [CNT_W-1:0] t_len;

  assign accept = in_valid && in_ready;
  assign t_len  = (state_q == ST_GUARD) ? CNT_W'(GUARD_LEN) : CNT_W'(PHASE_CYCLES);
  assign t_clr  = (state_d != state_q);
  assign adv    = (state_q == ST_HIGH) && t_done && !at_last;

  tw_phase_timer #(.CNT_W(CNT_W)) u_timer (
    .clk(clk), .rst(rst), .clr(t_clr), .len(t_len), .done(t_done)
  );

  tw_word_shifter #(.WORD_W(WORD_W)) u_shift (
    .clk(clk), .rst(rst), .load(accept), .adv(adv), .din(in_data),
    .bit_nxt(bit_d), .at_last(at_last)
  );

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_GUARD: if (t_done) state_d = ST_WAIT;
      ST_WAIT,
      ST_HOLD:  if (in_valid) state_d = ST_LOW;
      ST_LOW:   if (t_done) state_d = ST_HIGH;
      ST_HIGH:  if (t_done) begin
        if (!at_last)    state_d = ST_LOW;
        else if (last_q) state_d = ST_GUARD;
        else             state_d = ST_HOLD;
      end
      default:  state_d = ST_GUARD;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q  <= ST_GUARD;
      last_q   <= 1'b0;
      in_ready <= 1'b0;
      line_p   <= 1'b1;
      line_n   <= 1'b1;
    end else begin
      state_q  <= state_d;
      if (accept) last_q <= in_last;
      in_ready <= (state_d == ST_WAIT) || (state_d == ST_HOLD);
      unique case (state_d)
        ST_LOW: begin
          line_p <= 1'b0;
          line_n <= 1'b0;
        end
        ST_HIGH, ST_HOLD: begin
          line_p <= bit_d;
          line_n <= !bit_d;
        end
        default: begin
          line_p <= 1'b1;
          line_n <= 1'b1;
        end
      endcase
    end
  end

  AST_RESET_IDLE: assert property (@(posedge clk)
    rst |=> (line_p && line_n && !in_ready)); // R1
  AST_ACCEPT_STARTS_LOW: assert property (@(posedge clk) disable iff (rst)
    (in_valid && in_ready) |=> (!line_p && !line_n && !in_ready)); // R2
  AST_IDLE_EXIT_LOW: assert property (@(posedge clk) disable iff (rst)
    ($past(line_p) && $past(line_n)) |-> (line_p == line_n)); // R2
  AST_DATA_PHASE_EXIT: assert property (@(posedge clk) disable iff (rst)
    ($past(line_p) != $past(line_n)) |-> ((line_p == $past(line_p)) || (line_p == line_n))); // R3
  AST_QUIET_NOT_READY: assert property (@(posedge clk) disable iff (rst)
    (!line_p && !line_n) |-> !in_ready); // R6
endmodule

// File: tb/tw_line_tx_bench.sv
`timescale 1ns/100ps
module tw_line_tx_bench;
  localparam int W = 32;
  localparam int P = 4;
  localparam int G = 2;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic in_valid = 1'b0;
  logic in_last = 1'b0;
  logic [W-1:0] in_data = '0;
  logic in_ready, line_p, line_n;

  always #2.5 clk = ~clk;

  tw_line_tx #(.WORD_W(W), .PHASE_CYCLES(P), .GUARD_PHASES(G)) u_tw_line_tx (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
    .in_data(in_data), .in_last(in_last), .line_p(line_p), .line_n(line_n)
  );

  int checks = 0;
  int fails  = 0;

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=0x%08h expected=0x%08h", req, act, exp);
    end
  endtask

  // line monitor
  bit         mon_on = 1'b0;
  logic [1:0] prev_pair = 2'b11;
  int         run_len = 0;
  logic       bitbuf [0:127];
  int nbits = 0, idle_closed = 0, low_err = 0, hi_err = 0, ill_err = 0, rdy_err = 0;

  function automatic bit legal(input logic [1:0] a, input logic [1:0] b);
    case (a)
      2'b11:   return b == 2'b00;
      2'b00:   return (b == 2'b01) || (b == 2'b10);
      default: return (b == 2'b00) || (b == 2'b11);
    endcase
  endfunction

  always @(negedge clk) begin
    if (mon_on) begin
      logic [1:0] cur;
      cur = {line_p, line_n};
      if (cur == 2'b00 && in_ready) rdy_err++;
      if (cur == prev_pair) begin
        run_len++;
      end else begin
        case (prev_pair)
          2'b00: if (run_len != P) low_err++;
          2'b01: begin
            if (nbits < 128) bitbuf[nbits] = 1'b0;
            nbits++;
            if (run_len < P) hi_err++;
          end
          2'b10: begin
            if (nbits < 128) bitbuf[nbits] = 1'b1;
            nbits++;
            if (run_len < P) hi_err++;
          end
          default: idle_closed++;
        endcase
        if (!legal(prev_pair, cur)) ill_err++;
        prev_pair = cur;
        run_len = 1;
      end
    end
  end

  function automatic logic [31:0] word_at(input int k);
    logic [31:0] w;
    for (int i = 0; i < 32; i++) w[i] = bitbuf[k*32 + i];
    return w;
  endfunction

  task automatic clear_mon();
    nbits = 0; idle_closed = 0; low_err = 0; hi_err = 0; ill_err = 0; rdy_err = 0;
  endtask

  task automatic send_word(input logic [31:0] d, input logic lst);
    while (!in_ready) begin @(posedge clk); #1; end
    in_valid = 1'b1; in_data = d; in_last = lst;
    @(posedge clk); #1;
    in_valid = 1'b0;
  endtask

  task automatic finish_txn(input string tag);
    int n;
    n = 0;
    while (!(in_ready && line_p && line_n) && n < 5000) begin @(posedge clk); #1; n++; end
    chk(run_len == G*P, {"R8 closing idle ", tag}, run_len, G*P);
    chk(low_err == 0, {"R2 low phase length ", tag}, low_err, 0);
    chk(hi_err == 0, {"R3/R4 data phase length ", tag}, hi_err, 0);
    chk(ill_err == 0, {"R3 line transitions ", tag}, ill_err, 0);
    chk(rdy_err == 0, {"R6 ready while low ", tag}, rdy_err, 0);
  endtask

  task automatic t_reset();
    int n;
    repeat (3) @(posedge clk);
    #1;
    chk(line_p && line_n, "R1 wires high in reset", {line_p, line_n}, 2'b11);
    chk(!in_ready, "R1 ready low in reset", in_ready, 0);
    mon_on = 1'b1;
    @(posedge clk); #1;
    rst = 1'b0;
    n = 0;
    while (!in_ready && n < 1000) begin @(posedge clk); #1; n++; end
    chk(n == G*P, "R8 guard after reset", n, G*P);
  endtask

  task automatic t_byte_ca();
    logic [7:0] s;
    clear_mon();
    send_word(32'h0000_00CA, 1'b1);
    finish_txn("0xCA");
    for (int i = 0; i < 8; i++) s[i] = bitbuf[i];
    chk(s == 8'hCA, "R9 symbol order of 0xCA", s, 8'hCA);
    chk(nbits == 32, "R5 bit count", nbits, 32);
    chk(word_at(0) == 32'hCA, "R5 word value", word_at(0), 32'hCA);
    chk(idle_closed == 1, "R7 single opening idle", idle_closed, 1);
  endtask

  task automatic t_patterns();
    logic [31:0] pats [4];
    pats[0] = 32'h0000_0000; pats[1] = 32'hFFFF_FFFF;
    pats[2] = 32'h8000_0001; pats[3] = 32'hA5A5_3C3C;
    for (int k = 0; k < 4; k++) begin
      clear_mon();
      send_word(pats[k], 1'b1);
      finish_txn("pattern");
      chk(nbits == 32, "R5 bit count pattern", nbits, 32);
      chk(word_at(0) == pats[k], "R3/R4/R5 pattern value", word_at(0), pats[k]);
    end
  endtask

  task automatic t_chain();
    clear_mon();
    send_word(32'h1357_9BDF, 1'b0);
    while (!in_ready) begin @(posedge clk); #1; end
    chk(line_p != line_n, "R7 hold keeps data pattern", {line_p, line_n}, 2'b01);
    repeat (7) begin @(posedge clk); #1; end
    send_word(32'h2468_ACE0, 1'b1);
    finish_txn("chain");
    chk(nbits == 64, "R7 chained bit count", nbits, 64);
    chk(word_at(0) == 32'h1357_9BDF, "R5 first chained word", word_at(0), 32'h1357_9BDF);
    chk(word_at(1) == 32'h2468_ACE0, "R5 second chained word", word_at(1), 32'h2468_ACE0);
    chk(idle_closed == 1, "R7 no idle inside chain", idle_closed, 1);
  endtask

  task automatic t_busy();
    int rdy_seen;
    clear_mon();
    send_word(32'h1234_5678, 1'b1);
    in_valid = 1'b1; in_data = 32'hFFFF_0000; in_last = 1'b0;
    rdy_seen = 0;
    repeat (30) begin @(posedge clk); #1; if (in_ready) rdy_seen++; end
    in_valid = 1'b0;
    chk(rdy_seen == 0, "R6 ready low while shifting", rdy_seen, 0);
    finish_txn("busy");
    chk(nbits == 32, "R6 busy valid adds no bits", nbits, 32);
    chk(word_at(0) == 32'h1234_5678, "R6 busy data ignored", word_at(0), 32'h1234_5678);
  endtask

  initial begin
    t_reset();
    t_byte_ca();
    t_patterns();
    t_chain();
    t_busy();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog expired actual=0x%08h expected=0x%08h", 0, 1);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule